// File: doc/BRIEF.md
# Sequential Unsigned Divider with Status Flags

This unit divides one unsigned integer by another for the execution stage of a small controller core. A one-cycle `start` strobe captures the operands and a mode select. The unit then forms one quotient bit per clock by restoring shift-and-subtract. When it finishes, it presents a packed quotient/remainder word with the arithmetic status flags and raises `done` for one cycle. Byte mode divides the low bytes of the operands and packs an 8-bit quotient above an 8-bit remainder. Word mode divides the full 16-bit operands and returns a 16-bit quotient above a 16-bit remainder.

A zero divisor is recognised as soon as the strobe arrives. The iteration is then skipped and `done` comes back on the next cycle with the overflow flag set. The carry flag is cleared on every completion. The auxiliary-carry flag is not computed: the value offered on `ac_in` when the operation starts is handed back unchanged with the result. The result and flags hold their values until the next completion.

Top module: `udiv_flags`

## Requirements
- R1: In byte mode (`word_mode`=0), result[15:8] is the quotient and result[7:0] the remainder of dividend[7:0] / divisor[7:0], and result[31:16] is zero. For example, 251/18 gives 0x0000_0D11.
- R2: In word mode (`word_mode`=1), result[31:16] is the 16-bit quotient and result[15:0] the 16-bit remainder of dividend / divisor.
- R3: `flag_cy` is 0 whenever `done` is high, whether or not the divisor was zero.
- R4: For a nonzero divisor, on completion `flag_ov`=0. `flag_n` equals the quotient's top bit (bit 7 in byte mode, bit 15 in word mode). `flag_z`=1 exactly when the quotient is zero.
- R5: A zero divisor (divisor[7:0] in byte mode, the full divisor in word mode) raises `done` in the cycle after the accepting edge, with `flag_ov`=1 and `flag_cy`=0. The result, `flag_n` and `flag_z` are then unspecified.
- R6: On completion, `flag_ac` equals the value of `ac_in` sampled on the accepting edge.
- R7: For a nonzero divisor, `done` is a one-cycle pulse 8 clock edges after the accepting edge in byte mode and 16 in word mode. `busy` is high from the accepting edge until the edge that raises `done`. The result and flags change only on an edge that raises `done`.
- R8: `start` while `busy` is high is ignored. Operand, mode and `ac_in` changes after the accepting edge do not affect the result.
- R9: A `start` sampled in the same cycle as a `done` pulse is accepted and begins a new operation.
- R10: After synchronous reset (`rst_n`=0), result is 0, all flags are 0, and `busy` and `done` are 0.
- R11: In byte mode the upper bytes of dividend and divisor are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operation request, accepted when not busy |
| word_mode | input | 1 | 1 selects 16-bit division, 0 selects byte division |
| dividend | input | 16 | Dividend, low byte only in byte mode |
| divisor | input | 16 | Divisor, low byte only in byte mode |
| ac_in | input | 1 | Incoming auxiliary-carry value, returned unchanged |
| result | output | 32 | Packed quotient (upper part) and remainder (lower part) |
| flag_cy | output | 1 | Carry flag, always cleared |
| flag_ac | output | 1 | Auxiliary-carry flag, passed through |
| flag_ov | output | 1 | Overflow flag, set on a zero divisor |
| flag_n | output | 1 | Quotient top bit |
| flag_z | output | 1 | Quotient-is-zero flag |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. During a `done` pulse `busy` is already low, so a strobe held there must start a fresh division without disturbing the result just delivered. The bench provokes this by raising `start` in the very cycle it observes `done`. It does so after both byte and word operations, and also chains zero-divisor strobes so that `done` stays high for consecutive cycles. A cycle-accurate behavioural model predicts `busy`, `done`, the result and the flags on every clock. The overlap is judged correct when the second operation's result appears exactly 8 or 16 edges after that overlapping edge and the first result stayed intact until then.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

   typedef struct packed {
      logic cy;
      logic ac;
      logic ov;
      logic n;
      logic z;
   } udiv_flags_t;

endpackage

// File: rtl/udiv_step.sv
module udiv_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] rem_i,
   input  logic         bit_i,
   input  logic [W-1:0] dvs_i,
   output logic [W-1:0] rem_o,
   output logic         qbit_o
);

   logic [W:0] shifted;
   logic [W:0] trial;

   assign shifted = {rem_i, bit_i};
   assign trial   = shifted - {1'b0, dvs_i};
   // no borrow means the divisor fits: keep the difference
   assign qbit_o  = ~trial[W];
   assign rem_o   = trial[W] ? shifted[W-1:0] : trial[W-1:0];

endmodule

// File: rtl/udiv_seq.sv
module udiv_seq #(
   parameter int WORD_W  = 16,
   parameter int BYTE_W  = 8,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              word_mode,
   input  logic [WORD_W-1:0] dividend,
   input  logic [WORD_W-1:0] divisor,
   input  logic              ac_in,
   output logic              busy,
   output logic              fin,
   output logic              fin_dz,
   output logic              fin_wmode,
   output logic              fin_ac,
   output logic [WORD_W-1:0] fin_quo,
   output logic [WORD_W-1:0] fin_rem
);

   localparam int CW  = $clog2(WORD_W + 1);
   localparam int PAD = WORD_W - BYTE_W;

   logic              eff_mode;
   logic [WORD_W-1:0] dvs_in;
   logic [WORD_W-1:0] quo_in;
   logic              accept;
   logic              last;

   logic              busy_q;
   logic [CW-1:0]     cnt_q;
   logic [WORD_W-1:0] rem_q;
   logic [WORD_W-1:0] quo_q;
   logic [WORD_W-1:0] div_q;
   logic              wm_q;
   logic              ac_q;

   logic [WORD_W-1:0] rem_nxt;
   logic [WORD_W-1:0] quo_nxt;
   logic              qbit;

   generate
      if (WORD_EN) begin : g_word
         assign eff_mode = word_mode;
      end else begin : g_byte_only
         assign eff_mode = 1'b0;
      end
   endgenerate

   assign dvs_in = eff_mode ? divisor  : {{PAD{1'b0}}, divisor[BYTE_W-1:0]};
   // byte dividend is placed at the top so the same shift chain serves both modes
   assign quo_in = eff_mode ? dividend : {dividend[BYTE_W-1:0], {PAD{1'b0}}};

   assign accept = start && !busy_q;
   assign fin_dz = accept && (dvs_in == '0);

   udiv_step #(.W(WORD_W)) u_step (
      .rem_i  (rem_q),
      .bit_i  (quo_q[WORD_W-1]),
      .dvs_i  (div_q),
      .rem_o  (rem_nxt),
      .qbit_o (qbit)
   );

   assign quo_nxt = {quo_q[WORD_W-2:0], qbit};
   assign last    = busy_q && (cnt_q == CW'(1));
   assign fin     = last || fin_dz;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         div_q  <= '0;
         wm_q   <= 1'b0;
         ac_q   <= 1'b0;
      end else if (accept && !fin_dz) begin
         busy_q <= 1'b1;
         cnt_q  <= eff_mode ? CW'(WORD_W) : CW'(BYTE_W);
         rem_q  <= '0;
         quo_q  <= quo_in;
         div_q  <= dvs_in;
         wm_q   <= eff_mode;
         ac_q   <= ac_in;
      end else if (busy_q) begin
         rem_q  <= rem_nxt;
         quo_q  <= quo_nxt;
         cnt_q  <= cnt_q - CW'(1);
         if (last) busy_q <= 1'b0;
      end
   end

   assign busy      = busy_q;
   assign fin_wmode = fin_dz ? eff_mode : wm_q;
   assign fin_ac    = fin_dz ? ac_in : ac_q;
   assign fin_quo   = quo_nxt;
   assign fin_rem   = rem_nxt;

endmodule

// File: rtl/udiv_flag_gen.sv
module udiv_flag_gen
   import udiv_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic                wmode,
   input  logic                dz,
   input  logic                ac,
   input  logic [WORD_W-1:0]   quo,
   input  logic [WORD_W-1:0]   rem,
   output logic [2*WORD_W-1:0] res,
   output udiv_flags_t         flg
);

   localparam int RPAD = 2*WORD_W - 2*BYTE_W;

   always_comb begin
      flg    = '0;
      flg.ac = ac;
      if (dz) begin
         res    = '0;
         flg.ov = 1'b1;
      end else if (wmode) begin
         res   = {quo, rem};
         flg.n = quo[WORD_W-1];
         flg.z = (quo == '0);
      end else begin
         res   = {{RPAD{1'b0}}, quo[BYTE_W-1:0], rem[BYTE_W-1:0]};
         flg.n = quo[BYTE_W-1];
         flg.z = (quo[BYTE_W-1:0] == '0);
      end
   end

endmodule

// File: rtl/udiv_flags.sv
module udiv_flags
   import udiv_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int BYTE_W  = 8,
   parameter bit WORD_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                word_mode,
   input  logic [WORD_W-1:0]   dividend,
   input  logic [WORD_W-1:0]   divisor,
   input  logic                ac_in,
   output logic [2*WORD_W-1:0] result,
   output logic                flag_cy,
   output logic                flag_ac,
   output logic                flag_ov,
   output logic                flag_n,
   output logic                flag_z,
   output logic                busy,
   output logic                done
);

   generate
      if (BYTE_W < 2 || BYTE_W >= WORD_W) begin : g_bad_width
         $error("udiv_flags: BYTE_W must be at least 2 and below WORD_W");
      end
   endgenerate

   logic                fin, fin_dz, fin_wmode, fin_ac;
   logic [WORD_W-1:0]   fin_quo, fin_rem;
   logic [2*WORD_W-1:0] res_c;
   udiv_flags_t         flg_c;
   logic [2*WORD_W-1:0] res_q;
   udiv_flags_t         flg_q;
   logic                done_q;

   udiv_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .WORD_EN(WORD_EN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .word_mode (word_mode),
      .dividend  (dividend),
      .divisor   (divisor),
      .ac_in     (ac_in),
      .busy      (busy),
      .fin       (fin),
      .fin_dz    (fin_dz),
      .fin_wmode (fin_wmode),
      .fin_ac    (fin_ac),
      .fin_quo   (fin_quo),
      .fin_rem   (fin_rem)
   );

   udiv_flag_gen #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_flags (
      .wmode (fin_wmode),
      .dz    (fin_dz),
      .ac    (fin_ac),
      .quo   (fin_quo),
      .rem   (fin_rem),
      .res   (res_c),
      .flg   (flg_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         flg_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin;
         if (fin) begin
            res_q <= res_c;
            flg_q <= flg_c;
         end
      end
   end

   assign result  = res_q;
   assign flag_cy = flg_q.cy;
   assign flag_ac = flg_q.ac;
   assign flag_ov = flg_q.ov;
   assign flag_n  = flg_q.n;
   assign flag_z  = flg_q.z;
   assign done    = done_q;

endmodule

// File: rtl/udiv_flags_chk.sv
module udiv_flags_chk #(
   parameter int WORD_W  = 16,
   parameter int BYTE_W  = 8,
   parameter bit WORD_EN = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                word_mode,
   input logic [WORD_W-1:0]   divisor,
   input logic [2*WORD_W-1:0] result,
   input logic                flag_cy,
   input logic                flag_ov,
   input logic                busy,
   input logic                done
);

   logic zero_dvs;
   assign zero_dvs = (WORD_EN && word_mode) ? (divisor == '0)
                                            : (divisor[BYTE_W-1:0] == '0);

   // R3
   cy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !flag_cy);

   // R5
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && zero_dvs) |=> (done && flag_ov && !busy));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   // R9
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !zero_dvs) |=> (busy && !done));

endmodule

bind udiv_flags udiv_flags_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .WORD_EN(WORD_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .word_mode (word_mode),
   .divisor   (divisor),
   .result    (result),
   .flag_cy   (flag_cy),
   .flag_ov   (flag_ov),
   .busy      (busy),
   .done      (done)
);

// File: tb/udiv_flags_tb.sv
`timescale 1ns/1ps
module udiv_flags_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        word_mode = 1'b0;
   logic [15:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        ac_in = 1'b0;
   logic [31:0] result;
   logic        flag_cy, flag_ac, flag_ov, flag_n, flag_z, busy, done;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   udiv_flags u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
      .dividend(dividend), .divisor(divisor), .ac_in(ac_in),
      .result(result), .flag_cy(flag_cy), .flag_ac(flag_ac), .flag_ov(flag_ov),
      .flag_n(flag_n), .flag_z(flag_z), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   bit          m_busy, m_done, m_valid, m_dz, m_wm;
   int          m_cnt;
   logic [31:0] m_res, p_res;
   bit          m_ov, m_n, m_z, m_ac, p_n, p_z, p_ac;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_valid = 1; m_dz = 0; m_cnt = 0;
         m_res = 0; m_ov = 0; m_n = 0; m_z = 0; m_ac = 0; m_wm = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1; m_valid = 1; m_dz = 0;
               m_res = p_res; m_n = p_n; m_z = p_z; m_ac = p_ac; m_ov = 0;
            end
         end else if (start) begin
            int a, b, q, r;
            a = word_mode ? int'(dividend) : int'(dividend[7:0]);
            b = word_mode ? int'(divisor)  : int'(divisor[7:0]);
            if (b == 0) begin
               m_done = 1; m_dz = 1; m_valid = 0; m_ov = 1; m_ac = ac_in;
            end else begin
               q = a / b; r = a % b;
               m_wm = word_mode;
               if (word_mode) begin
                  p_res = {q[15:0], r[15:0]}; p_n = q[15];
               end else begin
                  p_res = {16'h0, q[7:0], r[7:0]}; p_n = q[7];
               end
               p_z = (q == 0); p_ac = ac_in;
               m_busy = 1; m_cnt = word_mode ? 16 : 8;
            end
         end
      end
   end

   // compare with the model shortly after each edge
   initial begin
      forever begin
         @(posedge clk); #2;
         if (rst_n) begin
            chk(busy == m_busy, "R7 busy", {31'b0, busy}, {31'b0, m_busy});
            chk(done == m_done, "R7 done", {31'b0, done}, {31'b0, m_done});
            chk(flag_cy == 1'b0, "R3 cy", {31'b0, flag_cy}, 32'h0);
            chk(flag_ac == m_ac, "R6 ac", {31'b0, flag_ac}, {31'b0, m_ac});
            if (m_dz)
               chk(flag_ov == 1'b1, "R5 ov", {31'b0, flag_ov}, 32'h1);
            if (m_valid) begin
               chk(result == m_res, m_wm ? "R2 result" : "R1 result", result, m_res);
               chk(flag_ov == m_ov, "R4 ov", {31'b0, flag_ov}, {31'b0, m_ov});
               chk(flag_n == m_n, "R4 n", {31'b0, flag_n}, {31'b0, m_n});
               chk(flag_z == m_z, "R4 z", {31'b0, flag_z}, {31'b0, m_z});
            end
         end
      end
   end

   task automatic go(input bit wm, input logic [15:0] a, input logic [15:0] b, input bit ac);
      @(negedge clk);
      start = 1; word_mode = wm; dividend = a; divisor = b; ac_in = ac;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_done();
      int n = 0;
      if (done) return;
      while (!done && n < 40) begin
         @(posedge clk); #1; n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(result == 0, "R10 result", result, 0);
      chk({flag_cy, flag_ac, flag_ov, flag_n, flag_z, busy, done} == 0, "R10 flags",
          {25'b0, flag_cy, flag_ac, flag_ov, flag_n, flag_z, busy, done}, 0);
      rst_n = 1;

      // R1 worked example, R11 upper bytes set to garbage
      go(0, 16'hA5FB, 16'h3C12, 1);
      wait_done();
      chk(result == 32'h0000_0D11, "R1 R11 251/18", result, 32'h0000_0D11);
      chk(flag_ac == 1'b1, "R6 ac returned", {31'b0, flag_ac}, 32'h1);

      // R2 word mode
      go(1, 16'd60000, 16'd7, 0);
      wait_done();
      chk(result == {16'd8571, 16'd3}, "R2 60000/7", result, {16'd8571, 16'd3});

      // R5 zero divisor in byte mode with nonzero upper divisor byte (R11)
      go(0, 16'h0042, 16'hFF00, 1);
      chk(done && flag_ov && !flag_cy, "R5 R11 zero byte divisor",
          {29'b0, done, flag_ov, flag_cy}, 32'h6);

      // R4 zero quotient and top-bit quotient
      go(0, 16'd5, 16'd9, 0);
      wait_done();
      chk(flag_z && !flag_n, "R4 zero quotient", {30'b0, flag_z, flag_n}, 32'h2);
      go(0, 16'd255, 16'd1, 0);
      wait_done();
      chk(result == 32'h0000_FF00 && flag_n, "R4 top bit", result, 32'h0000_FF00);

      // R8 start while busy is ignored, inputs changed after capture
      go(0, 16'd200, 16'd3, 0);
      repeat (3) begin
         @(negedge clk);
         start = 1; word_mode = 1; dividend = 16'hFFFF; divisor = 16'h0001; ac_in = 1;
      end
      @(negedge clk); start = 0;
      wait_done();
      chk(result == {16'h0, 8'd66, 8'd2}, "R8 ignored start", result, {16'h0, 8'd66, 8'd2});

      // R9 back-to-back: start during done cycle
      go(1, 16'd1000, 16'd10, 0);
      wait_done();
      go(0, 16'd100, 16'd9, 1);
      chk(busy == 1'b1, "R9 accepted in done cycle", {31'b0, busy}, 32'h1);
      wait_done();
      chk(result == {16'h0, 8'd11, 8'd1}, "R9 second result", result, {16'h0, 8'd11, 8'd1});
      // chained zero divisors: done high on consecutive cycles
      go(1, 16'd7, 16'd0, 0);
      go(1, 16'd7, 16'd0, 1);

      // randomized mix, checked by the model
      for (int i = 0; i < 300; i++) begin
         logic [15:0] b;
         b = 16'($urandom);
         if ((i % 11) == 0) b = 16'h0;
         if ((i % 5) == 0) b = b & 16'h000F;
         go(1'($urandom), 16'($urandom), b, 1'($urandom));
         if ((i % 3) != 0) wait_done();
      end
      repeat (20) @(negedge clk);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule